// File: doc/BRIEF.md
# ADC Control Register and Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter inside a small microcontroller. The CPU reads and writes one 8-bit control byte. That byte selects the analog input channel, the reference source and the conversion clock ratio. It also powers the reference ladder and starts a conversion. The sequencer divides the system clock into conversion ticks. It spends one tick sampling and then resolves one result bit per tick, from the most significant bit down. On each tick it drives a trial code to the external DAC and reads back a single comparator bit.

The run flag is one-way. Software can set it but cannot clear it, and the hardware clears it when the conversion ends. A start request made while the ladder is powered down is rejected on the first tick and raises an error flag. The block also decides which function owns the pin that is shared between the external reference, the timer clock input and general-purpose I/O.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x00: internal reference, divide-by-16, idle, ladder off, channel 0. The error flag and the done strobe are low.
- R2: Control byte fields: bit 7 is the external-reference select, bits 6:5 are the clock ratio code, bit 4 is the run flag, bit 3 is the ladder power enable, and bits 2:0 are the channel. A write while idle shows up in the read value on the next cycle.
- R3: Ratio code 00 gives 16 system clocks per conversion tick, 01 gives 4, 10 gives 64 and 11 gives 1. The tick divider restarts on an accepted start, so the first tick falls one full tick period after the start write.
- R4: Writing 1 to the run flag while idle starts a conversion. Writing 0 to it has no effect. Only the end of a conversion, or its rejection, clears it.
- R5: A powered conversion spends one tick in sampling, with the sample output high, then resolves 10 bits MSB first, one per tick. The comparator input is 1 when the analog input is at or above the DAC code, and a bit is kept exactly when it is 1. On the 11th tick edge the done strobe pulses for one cycle, the result output loads, and the run flag clears.
- R6: If the ladder is off when a conversion starts, the first tick clears the run flag without a done pulse and sets the error flag. The next accepted start clears the error flag.
- R7: A channel write made while a conversion runs leaves the channel output unchanged. The written value takes effect at the edge that ends the conversion.
- R8: The shared-pin function output is one-hot: bit 2 is reference, bit 1 is timer clock, bit 0 is GPIO. The reference takes priority over the timer-select input, and the timer takes priority over GPIO.
- R9: The reference-select output follows control bit 7 and the ladder power output follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte read value |
| tmr_src_sel | input | 1 | Timer clock taken from the shared pin |
| cmp_in | input | 1 | Comparator: analog input at or above DAC code |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | Sample phase active |
| chan_sel | output | 3 | Analog multiplexer select |
| ref_ext_sel | output | 1 | Reference taken from the shared pin |
| ladder_pwr_en | output | 1 | Reference ladder power enable |
| pin_fn | output | 3 | One-hot shared-pin function |
| conv_done | output | 1 | One-cycle end-of-conversion strobe |
| conv_result | output | 10 | Last conversion result |
| start_err | output | 1 | Start was rejected because the ladder was off |

## Verification
Register fields, and the outputs that mirror them, are due one cycle after the write edge. The pin function output is combinational. A powered conversion ends exactly 11 tick periods after the start edge, and a rejected start ends one tick period after it. The bench reference model counts these edges itself. It then compares every output in the middle of the low clock phase of every cycle, so it catches a done pulse or an error flag that comes one cycle early or late.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CH_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONV
    } seq_state_e;

    // Control byte, MSB first; the field order is the software-visible layout.
    typedef struct packed {
        logic            ext_ref;
        logic [1:0]      ratio;
        logic            run;
        logic            pwr_on;
        logic [CH_W-1:0] chan;
    } ctrl_reg_t;

    // System clocks per conversion tick for each ratio code.
    function automatic int unsigned ratio_div(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 4;
            2'b10:   return 64;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] ratio,
    output logic       tick
);
    import adc_seq_pkg::*;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim  = CNT_W'(ratio_div(ratio) - 1);
        tick = (cnt_q == lim);
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                tick,
    input  logic                pwr_on,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac,
    output logic                sample,
    output logic                finish,
    output logic                abort,
    output logic                done,
    output logic [RES_BITS-1:0] result
);
    import adc_seq_pkg::*;

    localparam int IDX_W = $clog2(RES_BITS);

    typedef struct packed {
        seq_state_e          st;
        logic [IDX_W-1:0]    idx;
        logic [RES_BITS-1:0] trial;
        logic [RES_BITS-1:0] res;
        logic                done;
    } sar_t;

    sar_t sar_d, sar_q;

    always_comb begin
        sar_d      = sar_q;
        sar_d.done = 1'b0;
        finish     = 1'b0;
        abort      = 1'b0;
        case (sar_q.st)
            ST_IDLE: begin
                if (start) begin
                    sar_d.st    = ST_SAMPLE;
                    sar_d.trial = '0;
                end
            end
            ST_SAMPLE: begin
                if (tick) begin
                    if (!pwr_on) begin
                        abort    = 1'b1;
                        sar_d.st = ST_IDLE;
                    end else begin
                        sar_d.st                 = ST_CONV;
                        sar_d.idx                = IDX_W'(RES_BITS - 1);
                        sar_d.trial              = '0;
                        sar_d.trial[RES_BITS-1]  = 1'b1;
                    end
                end
            end
            ST_CONV: begin
                if (tick) begin
                    sar_d.trial[sar_q.idx] = cmp_in;
                    if (sar_q.idx == '0) begin
                        finish     = 1'b1;
                        sar_d.st   = ST_IDLE;
                        sar_d.done = 1'b1;
                        sar_d.res  = sar_d.trial;
                    end else begin
                        sar_d.trial[sar_q.idx - 1'b1] = 1'b1;
                        sar_d.idx                     = sar_q.idx - 1'b1;
                    end
                end
            end
            default: sar_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '{st: ST_IDLE, default: '0};
        end else begin
            sar_q <= sar_d;
        end
    end

    assign dac    = sar_q.trial;
    assign sample = (sar_q.st == ST_SAMPLE);
    assign done   = sar_q.done;
    assign result = sar_q.res;

endmodule

// File: rtl/adc_pin_arb.sv
module adc_pin_arb (
    input  logic       ext_ref,
    input  logic       tmr_sel,
    output logic [2:0] fn
);
    // Fixed priority: reference over timer clock over GPIO.
    always_comb begin
        if (ext_ref) begin
            fn = 3'b100;
        end else if (tmr_sel) begin
            fn = 3'b010;
        end else begin
            fn = 3'b001;
        end
    end

endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [7:0]          cfg_wdata,
    output logic [7:0]          cfg_rdata,
    input  logic                tmr_src_sel,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sample_en,
    output logic [2:0]          chan_sel,
    output logic                ref_ext_sel,
    output logic                ladder_pwr_en,
    output logic [2:0]          pin_fn,
    output logic                conv_done,
    output logic [RES_BITS-1:0] conv_result,
    output logic                start_err
);
    import adc_seq_pkg::*;

    typedef struct packed {
        ctrl_reg_t       ctrl;
        logic [CH_W-1:0] pend;
        logic            pend_v;
        logic            err;
    } top_t;

    top_t      top_d, top_q;
    ctrl_reg_t wr_f;
    logic      start_req, tick, conv_fin, conv_abort, end_any;

    assign wr_f      = ctrl_reg_t'(cfg_wdata);
    assign start_req = cfg_wr && wr_f.run && !top_q.ctrl.run;
    assign end_any   = conv_fin || conv_abort;

    always_comb begin
        top_d = top_q;
        if (end_any) begin
            top_d.ctrl.run = 1'b0;
            if (top_q.pend_v) begin
                top_d.ctrl.chan = top_q.pend;
                top_d.pend_v    = 1'b0;
            end
            if (conv_abort) begin
                top_d.err = 1'b1;
            end
        end
        if (cfg_wr) begin
            top_d.ctrl.ext_ref = wr_f.ext_ref;
            top_d.ctrl.ratio   = wr_f.ratio;
            top_d.ctrl.pwr_on  = wr_f.pwr_on;
            if (top_q.ctrl.run && !end_any) begin
                top_d.pend   = wr_f.chan;
                top_d.pend_v = 1'b1;
            end else begin
                top_d.ctrl.chan = wr_f.chan;
            end
        end
        if (start_req) begin
            top_d.ctrl.run = 1'b1;
            top_d.err      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    adc_clk_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_req),
        .ratio   (top_q.ctrl.ratio),
        .tick    (tick)
    );

    adc_sar_core #(.RES_BITS(RES_BITS)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_req),
        .tick   (tick),
        .pwr_on (top_q.ctrl.pwr_on),
        .cmp_in (cmp_in),
        .dac    (dac_code),
        .sample (sample_en),
        .finish (conv_fin),
        .abort  (conv_abort),
        .done   (conv_done),
        .result (conv_result)
    );

    adc_pin_arb u_pin (
        .ext_ref (top_q.ctrl.ext_ref),
        .tmr_sel (tmr_src_sel),
        .fn      (pin_fn)
    );

    assign cfg_rdata     = top_q.ctrl;
    assign chan_sel      = top_q.ctrl.chan;
    assign ref_ext_sel   = top_q.ctrl.ext_ref;
    assign ladder_pwr_en = top_q.ctrl.pwr_on;
    assign start_err     = top_q.err;

endmodule

// File: rtl/adc_ctrl_seq_chk.sv
module adc_ctrl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       sample_en,
    input logic [2:0] chan_sel,
    input logic       ref_ext_sel,
    input logic [2:0] pin_fn,
    input logic       conv_done,
    input logic       start_err
);

    p_pin_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pin_fn));

    p_pin_ref_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ext_sel |-> (pin_fn == 3'b100));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    p_done_no_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> !sample_en);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> !cfg_rdata[4]);

    p_run_hw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rdata[4]) |-> (conv_done || $rose(start_err)));

    p_start_samples_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rdata[4]) |-> sample_en);

    p_chan_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[4] && $past(cfg_rdata[4])) |-> $stable(chan_sel));

endmodule

bind adc_ctrl_seq adc_ctrl_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .sample_en   (sample_en),
    .chan_sel    (chan_sel),
    .ref_ext_sel (ref_ext_sel),
    .pin_fn      (pin_fn),
    .conv_done   (conv_done),
    .start_err   (start_err)
);

// File: tb/adc_ctrl_seq_tb_top.sv
module adc_ctrl_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tmr_src_sel = 1'b0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       sample_en;
    logic [2:0] chan_sel;
    logic       ref_ext_sel;
    logic       ladder_pwr_en;
    logic [2:0] pin_fn;
    logic       conv_done;
    logic [9:0] conv_result;
    logic       start_err;

    int vin = 0;
    int n_total = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Comparator stand-in: high when the analog level is at or above the trial code.
    assign cmp_in = (int'(dac_code) <= vin);

    adc_ctrl_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tmr_src_sel(tmr_src_sel), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_en(sample_en), .chan_sel(chan_sel),
        .ref_ext_sel(ref_ext_sel), .ladder_pwr_en(ladder_pwr_en), .pin_fn(pin_fn),
        .conv_done(conv_done), .conv_result(conv_result), .start_err(start_err)
    );

    // Behavioural reference model.
    int m_vref, m_ratio, m_run, m_pwr, m_ch, m_pend, m_pv, m_err;
    int m_done, m_res, m_left, m_n, m_abort;

    function automatic int div_of(input int code);
        if (code == 0) return 16;
        if (code == 1) return 4;
        if (code == 2) return 64;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vref = 0; m_ratio = 0; m_run = 0; m_pwr = 0; m_ch = 0;
            m_pend = 0; m_pv = 0; m_err = 0; m_done = 0; m_res = 0;
            m_left = 0; m_n = 1; m_abort = 0;
        end else begin
            int was_run;
            was_run = m_run;
            m_done = 0;
            if (m_run != 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_run = 0;
                    if (m_abort != 0) m_err = 1;
                    else begin m_done = 1; m_res = vin; end
                    if (m_pv != 0) begin m_ch = m_pend; m_pv = 0; end
                end
            end
            if (cfg_wr) begin
                m_vref  = cfg_wdata[7];
                m_ratio = cfg_wdata[6:5];
                m_pwr   = cfg_wdata[3];
                if (m_run != 0) begin m_pend = cfg_wdata[2:0]; m_pv = 1; end
                else m_ch = cfg_wdata[2:0];
                if (cfg_wdata[4] && was_run == 0) begin
                    m_run   = 1;
                    m_err   = 0;
                    m_n     = div_of(cfg_wdata[6:5]);
                    m_abort = (cfg_wdata[3] == 1'b0);
                    m_left  = (m_abort != 0) ? m_n : 11 * m_n;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output in the middle of the low clock phase.
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            int exp_pin;
            exp_pin = (m_vref != 0) ? 4 : (tmr_src_sel ? 2 : 1);
            chk("R2 control byte", cfg_rdata,
                (m_vref << 7) | (m_ratio << 5) | (m_run << 4) | (m_pwr << 3) | m_ch);
            chk("R4 run flag", cfg_rdata[4], m_run);
            chk("R7 channel", chan_sel, m_ch);
            chk("R9 ref select", ref_ext_sel, m_vref);
            chk("R9 ladder power", ladder_pwr_en, m_pwr);
            chk("R8 pin function", pin_fn, exp_pin);
            chk("R3 R5 done strobe", conv_done, m_done);
            chk("R6 error flag", start_err, m_err);
            chk("R5 sample phase", sample_en,
                (m_run != 0 && (m_abort != 0 || m_left > 10 * m_n)) ? 1 : 0);
            if (m_done != 0) chk("R5 result", conv_result, m_res);
        end
    end

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 reset byte", cfg_rdata, 0);
        chk("R1 reset pin", pin_fn, 1);
        chk("R1 reset done", conv_done, 0);
        chk("R1 reset err", start_err, 0);

        wr(8'h0D);                      // ladder on, ch5, /16, idle
        idle(3);
        vin = 512;  wr(8'h7A); idle(20);   // /1, start, ch2
        vin = 341;  wr(8'h39); idle(6);    // /4, start, ch1
        wr(8'h2E); idle(60);               // run=0 write mid-run, channel deferred
        vin = 1023; wr(8'h1B); idle(200);  // /16
        vin = 0;    wr(8'h58); idle(720);  // /64
        vin = 700;  wr(8'h30); idle(10);   // ladder off: rejected start
        wr(8'h3C); idle(60);               // powered restart clears error
        tmr_src_sel = 1'b1; idle(2);
        wr(8'h88); idle(2);
        tmr_src_sel = 1'b0; idle(2);
        wr(8'h08); idle(3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_total++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule